// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around a single accumulator. It works through an explicit sequence of register transfers. The program counter is copied into a memory address register, and the addressed word is read into a memory data register. That word then moves into the current instruction register while the program counter advances by one. Then the instruction is decoded and executed, and control returns to the start of the sequence.

Instructions and data live in one shared synchronous memory. The memory is reached through a single address bus, a write-data bus, a read-data bus and one read strobe and one write strobe. Reads have one cycle of latency. Because instructions and data share the bus, an instruction fetch and a data access are never placed in the same cycle.

The instruction set has five operations: add immediate, load, store, branch when the zero flag is set, and no-operation. An add updates four status flags. The accumulator and the flags are brought out on ports so that a surrounding system can observe them.

Top module: `acc_core`

## Requirements
- R1: The read strobe `mem_rd` and the write strobe `mem_wr` are never high in the same cycle. An instruction fetch and a store always use separate cycles.
- R2: Each fetch spends one cycle loading the address register from the program counter. The next cycle drives `mem_rd` with `mem_addr` equal to the program counter. The first read after reset release falls in the second cycle, at address 0. Successive instructions are fetched from consecutive addresses.
- R3: A synchronous active-high `rst` clears the accumulator, the flags, the program counter and the instruction register. While `rst` is high and in the first cycle after its release, both strobes are low.
- R4: An instruction word is 12 bits: bits [11:8] are the opcode and bits [7:0] are the operand. Opcode 4'b0010 sets the 8-bit accumulator to the accumulator plus the operand, modulo 256.
- R5: After an add, `flags_o[0]` (zero) is 1 when the 8-bit result is 0. `flags_o[1]` (carry) is the carry out of bit 7. `flags_o[2]` (negative) is result bit 7. `flags_o[3]` (overflow) is set when both addends have the same bit 7 and the result's bit 7 differs from it.
- R6: Opcode 4'b0001 (load) sets the accumulator to bits [7:0] of the memory word at the operand address and leaves the flags unchanged. Between its fetch read and the next fetch read there are 7 cycles.
- R7: Opcode 4'b0011 (store) writes the accumulator, zero-extended to 12 bits, to the operand address with one cycle of `mem_wr`. It leaves the accumulator and the flags unchanged.
- R8: Opcode 4'b0100 (branch if zero) makes the next fetch come from the operand address when the zero flag is 1. Otherwise the next fetch comes from the incremented program counter.
- R9: Opcode 4'b0000 and opcodes 4'b0101 to 4'b1111 do nothing: no memory access, and no change to the accumulator or the flags.
- R10: Every instruction other than load takes 6 cycles from its fetch read to the next fetch read.
- R11: A store whose operand addresses the next instruction takes effect before that instruction is fetched, so the stored word is what gets executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Shared memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data appears on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 12 | Write data (accumulator, zero-extended) |
| mem_rdata | input | 12 | Read data from the shared memory |
| acc_o | output | 8 | Accumulator value |
| flags_o | output | 4 | Status flags: [0] zero, [1] carry, [2] negative, [3] overflow |

## Verification
The two functions that compete for the one memory bus are the instruction fetch and the store's data write. The sharpest test is a store aimed at the slot of the very next instruction, so that a write is followed closely by a fetch of the same address. The run is judged in three ways. The strobes must never overlap. The word that was originally in that slot (a load of a distinctive value) must not run. The accumulator must keep the value that was stored. A second pairing is a branch right after an add, where the branch decision must see the zero flag that the add produced in the previous execute step.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_NOP   = 4'b0000;
    localparam logic [OPC_W-1:0] OP_LOAD  = 4'b0001;
    localparam logic [OPC_W-1:0] OP_ADDI  = 4'b0010;
    localparam logic [OPC_W-1:0] OP_STORE = 4'b0011;
    localparam logic [OPC_W-1:0] OP_BZ    = 4'b0100;

    typedef enum logic [2:0] {
        ST_FMAR,   // address register <- program counter
        ST_FRD,    // read strobe at fetch address
        ST_FMDR,   // capture read word
        ST_FCIR,   // instruction register <- data register, pc + 1
        ST_DEC,    // decode, set up data address
        ST_EXE,    // execute
        ST_LDW     // load write-back
    } state_e;

    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } flags_t;

    typedef struct packed {
        logic rd_mem;
        logic wr_mem;
        logic mar_pc;
        logic mdr_cap;
        logic cir_cap;
        logic mar_opnd;
        logic alu_wr;
        logic br;
        logic ld_wb;
    } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output flags_t            flags
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    always_comb begin
        wide    = {1'b0, a} + {1'b0, b};
        sum     = wide[MSB:0];
        flags.z = (wide[MSB:0] == '0);
        flags.c = wide[DATA_W];
        flags.n = wide[MSB];
        flags.v = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctl
);

    state_e state_d, state_q;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        case (state_q)
            ST_FMAR: begin
                ctl.mar_pc = 1'b1;
                state_d    = ST_FRD;
            end
            ST_FRD: begin
                ctl.rd_mem = 1'b1;
                state_d    = ST_FMDR;
            end
            ST_FMDR: begin
                ctl.mdr_cap = 1'b1;
                state_d     = ST_FCIR;
            end
            ST_FCIR: begin
                ctl.cir_cap = 1'b1;
                state_d     = ST_DEC;
            end
            ST_DEC: begin
                ctl.mar_opnd = (opcode == OP_LOAD) || (opcode == OP_STORE);
                state_d      = ST_EXE;
            end
            ST_EXE: begin
                state_d = ST_FMAR;
                case (opcode)
                    OP_LOAD: begin
                        ctl.rd_mem = 1'b1;
                        state_d    = ST_LDW;
                    end
                    OP_ADDI:  ctl.alu_wr = 1'b1;
                    OP_STORE: ctl.wr_mem = 1'b1;
                    OP_BZ:    ctl.br     = 1'b1;
                    default:  ;
                endcase
            end
            ST_LDW: begin
                ctl.ld_wb = 1'b1;
                state_d   = ST_FMAR;
            end
            default: state_d = ST_FMAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FMAR;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [OPC_W+ADDR_W-1:0] mem_wdata,
    input  logic [OPC_W+ADDR_W-1:0] mem_rdata,
    output logic [DATA_W-1:0]       acc_o,
    output logic [3:0]              flags_o
);

    localparam int WORD_W = OPC_W + ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] mdr;
        logic [WORD_W-1:0] cir;
        logic [DATA_W-1:0] acc;
        flags_t            flags;
    } regs_t;

    regs_t             r_d, r_q;
    ctrl_t             ctl;
    logic [OPC_W-1:0]  opcode;
    logic [ADDR_W-1:0] operand;
    logic [DATA_W-1:0] sum;
    flags_t            alu_flags;

    assign opcode  = r_q.cir[WORD_W-1 -: OPC_W];
    assign operand = r_q.cir[ADDR_W-1:0];

    acc_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .ctl    (ctl)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .a     (r_q.acc),
        .b     (DATA_W'(operand)),
        .sum   (sum),
        .flags (alu_flags)
    );

    always_comb begin
        r_d = r_q;
        if (ctl.mar_pc)   r_d.mar = r_q.pc;
        if (ctl.mdr_cap)  r_d.mdr = mem_rdata;
        if (ctl.cir_cap) begin
            r_d.cir = r_q.mdr;
            r_d.pc  = r_q.pc + ADDR_W'(1);
        end
        if (ctl.mar_opnd) r_d.mar = operand;
        if (ctl.alu_wr) begin
            r_d.acc   = sum;
            r_d.flags = alu_flags;
        end
        if (ctl.br && r_q.flags.z) r_d.pc = operand;
        if (ctl.ld_wb) begin
            r_d.mdr = mem_rdata;
            r_d.acc = mem_rdata[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign mem_addr  = r_q.mar;
    assign mem_rd    = ctl.rd_mem;
    assign mem_wr    = ctl.wr_mem;
    assign mem_wdata = WORD_W'(r_q.acc);
    assign acc_o     = r_q.acc;
    assign flags_o   = r_q.flags;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] acc_o,
    input logic [3:0]        flags_o
);

    // R1
    no_bus_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R3
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (acc_o == '0) && (flags_o == 4'b0) && !mem_rd && !mem_wr);

    // R2
    read_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R7
    store_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_rd && !mem_wr && $stable(acc_o) && $stable(flags_o));

    // R1
    store_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(!mem_rd && !mem_wr));

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .acc_o   (acc_o),
    .flags_o (flags_o)
);

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata;
    logic [7:0]  acc_o;
    logic [3:0]  flags_o;

    logic [11:0] img [256];
    logic [11:0] mem [256];

    int checks = 0;
    int fails  = 0;
    int clashes = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    acc_core u_dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_o(acc_o), .flags_o(flags_o)
    );

    // memory model: synchronous, one cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            mem       <= img;
            mem_rdata <= '0;
        end else begin
            if (mem_wr) mem[mem_addr] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem[mem_addr];
        end
    end

    always @(negedge clk)
        if (!rst && mem_rd && mem_wr) clashes++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic prep();
        for (int i = 0; i < 256; i++) img[i] = 12'h123;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fetch_at(input logic [7:0] a, input string req, output int at);
        bit hit = 1'b0;
        for (int n = 0; n < 400 && !hit; n++) begin
            @(negedge clk);
            if (mem_rd && mem_addr == a) hit = 1'b1;
        end
        at = cyc;
        check(req, {31'd0, hit}, 32'd1);
    endtask

    task automatic t_add_basic();
        int t0, t1, t2;
        prep();
        img[0] = 12'h205; img[1] = 12'h203;
        do_reset();
        fetch_at(8'h00, "R2 fetch addr 0", t0);
        fetch_at(8'h01, "R2 fetch addr 1", t1);
        fetch_at(8'h02, "R2 fetch addr 2", t2);
        check("R4 acc 5+3", acc_o, 8'h08);
        check("R5 flags clear", flags_o, 4'b0000);
        check("R10 add cycles", t1 - t0, 6);
    endtask

    task automatic t_reset();
        int t0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R3 acc cleared", acc_o, 8'h00);
        check("R3 flags cleared", flags_o, 4'b0000);
        check("R3 strobes low", {mem_rd, mem_wr}, 2'b00);
        t0 = cyc;
        @(negedge clk);
        check("R2 first read in 2nd cycle", {mem_rd, mem_addr}, {1'b1, 8'h00});
        check("R2 read cycle index", cyc - t0, 1);
    endtask

    task automatic t_carry_zero();
        int t;
        prep();
        img[0] = 12'h2FF; img[1] = 12'h201;
        do_reset();
        fetch_at(8'h02, "R2 fetch addr 2", t);
        check("R4 acc wrap", acc_o, 8'h00);
        check("R5 zero+carry", flags_o, 4'b0011);
    endtask

    task automatic t_overflow();
        int t;
        prep();
        img[0] = 12'h27F; img[1] = 12'h201;
        do_reset();
        fetch_at(8'h02, "R2 fetch addr 2", t);
        check("R4 acc 7F+1", acc_o, 8'h80);
        check("R5 overflow+neg", flags_o, 4'b1100);
        prep();
        img[0] = 12'h2F0; img[1] = 12'h2F0;
        do_reset();
        fetch_at(8'h02, "R2 fetch addr 2", t);
        check("R4 acc F0+F0", acc_o, 8'hE0);
        check("R5 carry+neg no ovf", flags_o, 4'b0110);
    endtask

    task automatic t_load();
        int t1, t2;
        prep();
        img[0] = 12'h200; img[1] = 12'h1F0; img[8'hF0] = 12'h0AB;
        do_reset();
        fetch_at(8'h01, "R2 fetch addr 1", t1);
        fetch_at(8'h02, "R2 fetch addr 2", t2);
        check("R6 load value", acc_o, 8'hAB);
        check("R6 flags kept", flags_o, 4'b0001);
        check("R6 load cycles", t2 - t1, 7);
    endtask

    task automatic t_store();
        int t1, t2;
        prep();
        img[0] = 12'h2A5; img[1] = 12'h3F1;
        do_reset();
        fetch_at(8'h01, "R2 fetch addr 1", t1);
        fetch_at(8'h02, "R2 fetch addr 2", t2);
        check("R7 stored word", mem[8'hF1], 12'h0A5);
        check("R7 flags kept", flags_o, 4'b0100);
        check("R7 acc kept", acc_o, 8'hA5);
        check("R10 store cycles", t2 - t1, 6);
    endtask

    task automatic t_branch_taken();
        int t;
        prep();
        img[0] = 12'h200; img[1] = 12'h410; img[2] = 12'h201;
        img[8'h10] = 12'h3F2;
        do_reset();
        fetch_at(8'h10, "R8 fetch target", t);
        fetch_at(8'h11, "R8 fetch after target", t);
        check("R8 skipped add", acc_o, 8'h00);
        check("R8 target store ran", mem[8'hF2], 12'h000);
    endtask

    task automatic t_branch_not_taken();
        int t;
        prep();
        img[0] = 12'h201; img[1] = 12'h410; img[2] = 12'h202;
        img[8'h10] = 12'h240;
        do_reset();
        fetch_at(8'h03, "R8 fall through", t);
        check("R8 acc after fall through", acc_o, 8'h03);
    endtask

    task automatic t_nop();
        int t1, t2;
        prep();
        img[0] = 12'h207; img[1] = 12'hF55; img[2] = 12'h0AA; img[3] = 12'h5F0;
        do_reset();
        fetch_at(8'h01, "R2 fetch addr 1", t1);
        fetch_at(8'h02, "R2 fetch addr 2", t2);
        check("R9 nop cycles", t2 - t1, 6);
        fetch_at(8'h04, "R2 fetch addr 4", t2);
        check("R9 acc unchanged", acc_o, 8'h07);
        check("R9 flags unchanged", flags_o, 4'b0000);
        check("R9 mem 55 untouched", mem[8'h55], 12'h123);
        check("R9 mem AA untouched", mem[8'hAA], 12'h123);
        check("R9 mem F0 untouched", mem[8'hF0], 12'h123);
    endtask

    task automatic t_selfmod();
        int t;
        prep();
        img[0] = 12'h205; img[1] = 12'h302; img[2] = 12'h1F0; img[8'hF0] = 12'h0EE;
        do_reset();
        fetch_at(8'h03, "R11 fetch addr 3", t);
        check("R11 overwritten slot", mem[8'h02], 12'h005);
        check("R11 old load not run", acc_o, 8'h05);
    endtask

    initial begin
        #(400_000.0);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        prep();
        t_add_basic();
        t_reset();
        t_carry_zero();
        t_overflow();
        t_load();
        t_store();
        t_branch_taken();
        t_branch_not_taken();
        t_nop();
        t_selfmod();
        check("R1 strobe overlap count", clashes, 0);
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule